// File: doc/BRIEF.md
# Look-aside Read Cache Controller

This block sits beside a processor on a shared system bus that leads to a slower main memory. The processor issues a word address together with a read strobe. The controller looks the address up in a direct-mapped tag store. On a hit, it returns the word from its own data array in the same cycle. On a hit, the system-bus address and data buffers remain switched off, so the bus carries no traffic.

On a miss, the controller fetches the whole block that holds the requested word. It drives the block address onto the bus and collects one word for each accepted beat, starting at offset zero. Each returning word passes through the data buffer to two places at once: the line in the cache, and the processor. The processor's ready pulses on the beat that carries the word it asked for. Many memory blocks share each line. A later block with the same index evicts the one already held there.

Top module: `lookaside_rcache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses. Reset also drives `cpu_busy`, `bus_req`, `abuf_en`, `dbuf_en` and `cpu_ready` low.
- R2: A read whose line is valid and whose stored tag equals the address tag is a hit. `cpu_ready` rises in the same cycle as `cpu_rd`, carrying the stored word. In that cycle `bus_req`, `abuf_en` and `dbuf_en` stay low.
- R3: The word address splits into three fields. The low 2 bits are the word offset, the next 4 bits are the line index, and the remaining upper bits are the tag. On a miss, `bus_req`, `abuf_en` and `dbuf_en` rise on the next cycle. The first `bus_addr` is the block address with offset 0.
- R4: Fill beats use offsets 0, 1, 2, 3 in ascending order. The offset advances only when `bus_rdy` is high. While `bus_rdy` is low, `bus_req` and `bus_addr` stay unchanged, for any number of wait cycles.
- R5: During a fill, `cpu_ready` is high only on the single beat whose offset equals the requested offset. On that beat `cpu_rdata` equals `bus_rdata`.
- R6: After the last beat the line is valid and holds the new tag. Its modified bit is clear. A read of any word in that block then hits and returns the word that was filled.
- R7: `cpu_busy` is high from the cycle after a miss through the cycle of the last beat. A `cpu_rd` presented while busy is ignored: it starts no fill, gets no ready of its own, and leaves no data in the cache.
- R8: A block that maps to an occupied line with a different tag misses and replaces that line. The block it evicted misses on its next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_ready | output | 1 | Read data valid for the processor |
| cpu_rdata | output | DATA_W | Read data for the processor |
| cpu_busy | output | 1 | Fill in progress; reads are not accepted |
| bus_req | output | 1 | Bus beat request |
| bus_addr | output | ADDR_W | Bus word address of the current beat |
| bus_rdy | input | 1 | Bus beat accepted; data is valid |
| bus_rdata | input | DATA_W | Bus read data |
| abuf_en | output | 1 | System-bus address buffer enable |
| dbuf_en | output | 1 | System-bus data buffer enable |

## Verification
A hit answers in the cycle of the strobe. The bench therefore drives `cpu_rd` on a falling edge and samples ready, data and the bus signals shortly after, before the next rising edge. A miss shows `cpu_busy` and the block address one edge later, which is where those checks sample. Each beat's ready and data appear in the same cycle that the responder raises `bus_rdy`. A monitor checks them a little after each falling edge, popping the word that the driver queued. The responder inserts between 0 and 2 wait cycles before each beat. It checks that the offset order holds and that the address stays put while it stalls.

// File: rtl/rcache_pkg.sv
package rcache_pkg;
   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_FILL = 1'b1
   } fill_state_t;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return (r == 0) ? 1 : r;
   endfunction
endpackage

// File: rtl/rcache_tag_store.sv
module rcache_tag_store #(
   parameter int LINES = 16,
   parameter int IDX_W = 4,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] look_idx,
   input  logic [TAG_W-1:0] look_tag,
   output logic             look_hit,
   input  logic             inval_en,
   input  logic             fill_done,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag
);
   logic             valid_v [LINES];
   logic             dirty_v [LINES];
   logic [TAG_W-1:0] tag_v   [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic             v_q;
      logic             d_q;
      logic [TAG_W-1:0] t_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            t_q <= '0;
         end else if (fill_idx == IDX_W'(i)) begin
            if (inval_en) begin
               v_q <= 1'b0;
            end else if (fill_done) begin
               v_q <= 1'b1;
               d_q <= 1'b0;
               t_q <= fill_tag;
            end
         end
      end
      assign valid_v[i] = v_q;
      assign dirty_v[i] = d_q;
      assign tag_v[i]   = t_q;
   end

   assign look_hit = valid_v[look_idx] && (tag_v[look_idx] == look_tag);

   p_fill_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> valid_v[$past(fill_idx)] && !dirty_v[$past(fill_idx)]
                    && (tag_v[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/rcache_data_store.sv
module rcache_data_store #(
   parameter int DATA_W = 32,
   parameter int ENTRIES = 64,
   parameter int ENT_W = 6
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ENT_W-1:0]  wr_ent,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ENT_W-1:0]  rd_ent,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_ent] <= wr_data;
   end

   assign rd_data = mem_q[rd_ent];
endmodule

// File: rtl/rcache_fill_seq.sv
module rcache_fill_seq
   import rcache_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int OFF_W  = 2,
   parameter int WORDS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              hit,
   input  logic              bus_rdy,
   output logic              busy,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [ADDR_W-1:0] held_addr,
   output logic [OFF_W-1:0]  beat,
   output logic              fill_start,
   output logic              fill_we,
   output logic              fill_last,
   output logic              fill_fwd
);
   fill_state_t       state_q;
   logic [ADDR_W-1:0] req_q;
   logic [OFF_W-1:0]  beat_q;

   assign busy       = (state_q == FS_FILL);
   assign fill_start = !busy && cpu_rd && !hit;
   assign fill_we    = busy && bus_rdy;
   assign fill_last  = fill_we && (beat_q == OFF_W'(WORDS - 1));
   assign fill_fwd   = fill_we && (beat_q == req_q[OFF_W-1:0]);
   assign bus_addr   = {req_q[ADDR_W-1:OFF_W], beat_q};
   assign held_addr  = req_q;
   assign beat       = beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         req_q   <= '0;
         beat_q  <= '0;
      end else begin
         case (state_q)
            FS_IDLE: if (fill_start) begin
               state_q <= FS_FILL;
               req_q   <= cpu_addr;
               beat_q  <= '0;
            end
            FS_FILL: if (bus_rdy) begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == OFF_W'(WORDS - 1)) state_q <= FS_IDLE;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   p_start_needs_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cpu_rd));
   p_first_beat_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (bus_addr[OFF_W-1:0] == '0)
                      && (bus_addr[ADDR_W-1:OFF_W] == $past(cpu_addr[ADDR_W-1:OFF_W])));
   p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bus_rdy) |=> busy && $stable(bus_addr));
endmodule

// File: rtl/lookaside_rcache.sv
module lookaside_rcache
   import rcache_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int LINES  = 16,
   parameter int WORDS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_busy,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rdy,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              abuf_en,
   output logic              dbuf_en
);
   localparam int OFF_W   = clog2_min1(WORDS);
   localparam int IDX_W   = clog2_min1(LINES);
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
   localparam int ENTRIES = LINES * WORDS;
   localparam int ENT_W   = IDX_W + OFF_W;

   if ((1 << OFF_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic              hit, busy, fill_start, fill_we, fill_last, fill_fwd;
   logic [ADDR_W-1:0] held_addr;
   logic [OFF_W-1:0]  beat;
   logic [DATA_W-1:0] array_word;
   logic [IDX_W-1:0]  cpu_idx, held_idx, tag_idx;

   assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
   assign held_idx = held_addr[OFF_W +: IDX_W];
   assign tag_idx  = busy ? held_idx : cpu_idx;

   rcache_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_idx  (cpu_idx),
      .look_tag  (cpu_addr[ADDR_W-1 -: TAG_W]),
      .look_hit  (hit),
      .inval_en  (fill_start),
      .fill_done (fill_last),
      .fill_idx  (tag_idx),
      .fill_tag  (held_addr[ADDR_W-1 -: TAG_W])
   );

   rcache_data_store #(.DATA_W(DATA_W), .ENTRIES(ENTRIES), .ENT_W(ENT_W)) i_data (
      .clk     (clk),
      .wr_en   (fill_we),
      .wr_ent  ({held_idx, beat}),
      .wr_data (bus_rdata),
      .rd_ent  (cpu_addr[ENT_W-1:0]),
      .rd_data (array_word)
   );

   rcache_fill_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORDS(WORDS)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_rd     (cpu_rd),
      .cpu_addr   (cpu_addr),
      .hit        (hit),
      .bus_rdy    (bus_rdy),
      .busy       (busy),
      .bus_addr   (bus_addr),
      .held_addr  (held_addr),
      .beat       (beat),
      .fill_start (fill_start),
      .fill_we    (fill_we),
      .fill_last  (fill_last),
      .fill_fwd   (fill_fwd)
   );

   assign cpu_busy  = busy;
   assign bus_req   = busy;
   assign abuf_en   = busy;
   assign dbuf_en   = busy;
   assign cpu_ready = busy ? fill_fwd : (cpu_rd && hit);
   assign cpu_rdata = busy ? bus_rdata : array_word;

   p_hit_bus_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !cpu_busy) |-> !bus_req && !abuf_en && !dbuf_en);
   p_fwd_on_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && cpu_busy) |-> bus_rdy && (cpu_rdata == bus_rdata)
                                  && (bus_addr == held_addr));
   p_miss_starts_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !cpu_busy && !cpu_ready) |=> cpu_busy && bus_req);
endmodule

// File: tb/test_lookaside_rcache.sv
`timescale 1ns/100ps
module test_lookaside_rcache;
   localparam int AW = 12, DW = 32, NL = 16, NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_rd = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_ready, cpu_busy, bus_req, abuf_en, dbuf_en;
   logic [DW-1:0] cpu_rdata;
   logic [AW-1:0] bus_addr;
   logic          bus_rdy = 1'b0;
   logic [DW-1:0] bus_rdata = '0;

   int n_chk = 0, n_bad = 0;
   int wait_mode = 0;
   logic [DW-1:0] exp_q[$];
   logic [AW-1:0] exp_base = '0;
   int            fwd_seen = 0;
   logic          mdl_v [NL];
   logic [5:0]    mdl_t [NL];

   always #2.5 clk = ~clk;

   lookaside_rcache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WORDS(NW)) i_lookaside_rcache (
      .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdy(bus_rdy),
      .bus_rdata(bus_rdata), .abuf_en(abuf_en), .dbuf_en(dbuf_en));

   function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
      return {a, 4'hC, a ^ 12'h5A3, 4'h9};
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // bus responder: variable waits, checks offset order and stall stability (R4)
   initial begin
      int wcnt = 0;
      int beat = 0;
      logic [AW-1:0] last_a = '0;
      logic stalled = 1'b0;
      forever begin
         @(negedge clk);
         bus_rdy = 1'b0;
         if (bus_req) begin
            if (stalled) check("R4 stall addr", {20'd0, bus_addr}, {20'd0, last_a});
            if (wcnt > 0) begin
               wcnt--;
               stalled = 1'b1;
               last_a = bus_addr;
            end else begin
               check("R4 beat order", {20'd0, bus_addr}, {20'd0, exp_base + AW'(beat)});
               bus_rdy = 1'b1;
               bus_rdata = mem_word(bus_addr);
               beat = (beat + 1) % NW;
               wcnt = (wait_mode + beat) % 3;
               stalled = 1'b0;
            end
         end else begin
            beat = 0;
            wcnt = wait_mode % 3;
            stalled = 1'b0;
         end
      end
   end

   // monitor: pops forwarded words during fills (R5)
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (cpu_ready && cpu_busy) begin
            fwd_seen++;
            if (exp_q.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R5 unexpected ready: actual %h expected none", cpu_rdata);
            end else check("R5 forwarded word", cpu_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic cpu_read(input logic [AW-1:0] a, input bit inject, input logic [AW-1:0] inj_a);
      logic [3:0] idx;
      bit exp_hit;
      idx = a[5:2];
      exp_hit = mdl_v[idx] && (mdl_t[idx] == a[11:6]);
      @(negedge clk);
      cpu_rd = 1'b1;
      cpu_addr = a;
      #1;
      if (exp_hit) begin
         check("R2 hit ready", {31'd0, cpu_ready}, 32'd1);
         check("R6 hit data", cpu_rdata, mem_word(a));
         check("R2 bus quiet", {29'd0, bus_req, abuf_en, dbuf_en}, 32'd0);
         @(negedge clk);
         cpu_rd = 1'b0;
         #1 check("R2 no fill after hit", {31'd0, cpu_busy}, 32'd0);
      end else begin
         check("R1/R8 miss no ready", {31'd0, cpu_ready}, 32'd0);
         exp_base = {a[AW-1:2], 2'b00};
         exp_q.push_back(mem_word(a));
         fwd_seen = 0;
         @(negedge clk);
         cpu_rd = 1'b0;
         check("R3 busy and buffers", {29'd0, cpu_busy, abuf_en, dbuf_en}, 32'd7);
         check("R3 base addr", {20'd0, bus_addr}, {20'd0, exp_base});
         if (inject) begin
            @(negedge clk);
            cpu_rd = 1'b1;
            cpu_addr = inj_a;
            @(negedge clk);
            cpu_rd = 1'b0;
         end
         while (cpu_busy) @(negedge clk);
         #2;
         check("R5 single forward", fwd_seen, 1);
         check("R7 no refill", {30'd0, bus_req, cpu_busy}, 32'd0);
         mdl_v[idx] = 1'b1;
         mdl_t[idx] = a[11:6];
      end
   endtask

   initial begin
      for (int i = 0; i < NL; i++) begin mdl_v[i] = 1'b0; mdl_t[i] = '0; end
      repeat (3) @(negedge clk);
      #1;
      check("R1 reset outputs", {27'd0, cpu_busy, bus_req, abuf_en, dbuf_en, cpu_ready}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_mode = 0;
      cpu_read(12'h005, 1'b0, '0);               // R1 first read misses
      for (int w = 4; w < 8; w++) cpu_read(AW'(w), 1'b0, '0);   // R6 whole block hits
      wait_mode = 2;
      cpu_read(12'h013, 1'b0, '0);               // R5 last-offset forward with waits
      cpu_read(12'h010, 1'b0, '0);
      wait_mode = 1;
      cpu_read(12'h105, 1'b0, '0);               // R8 conflict, same index
      cpu_read(12'h106, 1'b0, '0);
      cpu_read(12'h005, 1'b0, '0);               // R8 evicted block misses
      cpu_read(12'h0A2, 1'b1, 12'h201);          // R7 read during fill ignored
      cpu_read(12'h0A0, 1'b0, '0);
      cpu_read(12'h201, 1'b0, '0);               // R7 ignored address still misses
      check("R5 queue drained", exp_q.size(), 0);
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule